// File: doc/BRIEF.md
# Eight-Channel Double-Buffered Converter Code Bank

This block is the digital front end of an eight-channel, 14-bit voltage-output converter. A host drives a parallel port made of a data word, a 3-bit channel address, an active-low chip select, an active-low write strobe, an active-low global load and an active-low clear. Each channel holds its code in two stages. The staging register of the addressed channel takes the host word while chip select and write are both low. The output registers of all eight channels take their staging contents together while load is low, so every channel changes on the same clock edge.

The controls are level-sensitive. They are modelled synchronously: chip select, write and load pass through a two-flop synchronizer, and data and address are delayed by the same two flops so that they stay aligned with the controls. When chip select, write and load are all low, the addressed channel's output follows the data bus through both stages in one register step. Clear raises a clamp flag at once, with no clock needed. The analog stage uses this flag to tie every output to its ground reference. Clear releases through the synchronizer and never alters any stored code. A build-time parameter selects two's complement input, which is converted to offset binary by inverting the most significant bit.

Top module: `dacbank_top`

## Requirements
- R1: While rst_n is low, every staging and output register is set to 0x0000 and clamp is 0.
- R2: Address value k (0 to 7) selects channel k, whose output code appears on dac_code bits [14k+13:14k]. No other channel changes.
- R3: The addressed staging register loads din while cs_n and wr_n are both low. It keeps its value while either cs_n or wr_n is high.
- R4: While ld_n is high, every output code holds its value, even when staging registers are written.
- R5: While ld_n is low, all eight output registers take their staging contents on the same clock edge.
- R6: With cs_n, wr_n and ld_n all low, the addressed channel's output code follows din, and each new din value appears after one register step.
- R7: A change on cs_n, wr_n, ld_n, addr or din first shows on dac_code at the third rising clock edge after it: two synchronizer edges, then one register edge.
- R8: clamp goes to 1 as soon as clr_n goes low, with no clock edge needed.
- R9: After clr_n returns high, clamp stays 1 through the first rising edge and goes to 0 on the second.
- R10: Clear changes no register: the output codes, and the staging contents transferred by a later load, are the same as before the clear.
- R11: With the format parameter set to two's complement, the stored code is din with bit 13 inverted. With offset binary, din is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low clear; drives the clamp flag |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low global transfer to the output registers |
| addr | input | 3 | Channel address, 0 = first channel |
| din | input | 14 | Host data word |
| dac_code | output | 112 | Eight output codes, channel k at bits [14k+13:14k] |
| clamp | output | 1 | High while the outputs must sit at ground reference |

## Verification
The bench writes a distinct word to each of the eight addresses while load is held high. Any code that moves at that point shows a hold failure. Any word that lands on the wrong channel after the load shows a decode fault. The load itself is sampled edge by edge: all channels must stay unchanged two edges after load falls and must all be updated after the third, which catches both a latency error and a transfer that reaches only some channels. Writes with only one of the two strobes low must leave the staging register alone. A stream of words in pass-through mode must each appear one step after the last. A clear pulse is checked against the flag timing and against the codes before and after it. A second instance in two's complement mode receives the same writes, and its codes must differ from the first instance's only in bit 13.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } code_fmt_e;
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dacbank_clamp.sv
module dacbank_clamp #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic clamp_o
);
  logic [STAGES-1:0] hold_q;

  // asserted asynchronously by clear, drained one stage per clock after release
  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (!clr_n) hold_q <= '1;
    else             hold_q <= {hold_q[STAGES-2:0], 1'b0};
  end

  assign clamp_o = hold_q[STAGES-1];

  // R8: clamp is up whenever clear is low at a clock edge
  a_r8_clamp_async: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> clamp_o);
  // R9: release is not immediate
  a_r9_clamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_n) |-> clamp_o);
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
  import dacbank_pkg::*;
#(
  parameter int        CW  = 14,
  parameter code_fmt_e FMT = FMT_OFFSET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          ld_n_i,
  input  logic [CW-1:0] data_i,
  output logic [CW-1:0] in_o,
  output logic [CW-1:0] dac_o
);
  localparam logic [CW-1:0] MSB_MASK = {1'b1, {(CW-1){1'b0}}};

  function automatic logic [CW-1:0] to_offset(input logic [CW-1:0] d,
                                              input code_fmt_e fmt);
    return (fmt == FMT_TWOS) ? (d ^ MSB_MASK) : d;
  endfunction

  logic [CW-1:0] conv_w;
  logic [CW-1:0] in_next_w;
  logic          pass_w;

  assign conv_w    = to_offset(data_i, FMT);
  assign in_next_w = wr_en_i ? conv_w : in_o;
  assign pass_w    = wr_en_i && !ld_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_o  <= '0;
      dac_o <= '0;
    end else begin
      in_o <= in_next_w;
      if (!ld_n_i) dac_o <= in_next_w;
    end
  end

  // R3: staging register keeps its value unless written
  a_r3_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(in_o));
  // R4: output register keeps its value while load is high
  a_r4_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n_i |=> $stable(dac_o));
  // R6: flow-through reaches the output in one register step
  a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
    pass_w |=> (dac_o == in_o));
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int        NCH    = 8,
  parameter int        CW     = 14,
  parameter int        SYNC   = 2,
  parameter code_fmt_e FMT    = FMT_OFFSET,
  localparam int       AW     = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic [AW-1:0]     addr,
  input  logic [CW-1:0]     din,
  output logic [NCH*CW-1:0] dac_code,
  output logic              clamp
);
  localparam int DW = AW + CW;

  logic [2:0]      ctrl_s;
  logic            cs_s, wr_s, ld_s;
  logic [DW-1:0]   bus_s;
  logic [AW-1:0]   addr_s;
  logic [CW-1:0]   data_s;
  logic            strobe_w;
  logic [NCH-1:0]  wen_vec;
  logic [NCH*CW-1:0] in_flat;

  dacbank_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b111)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_n, wr_n, ld_n}), .q_o(ctrl_s));

  // data and address ride the same number of flops to stay aligned with controls
  dacbank_sync #(.W(DW), .STAGES(SYNC), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_i({addr, din}), .q_o(bus_s));

  assign {cs_s, wr_s, ld_s} = ctrl_s;
  assign {addr_s, data_s}   = bus_s;
  assign strobe_w           = !cs_s && !wr_s;

  dacbank_clamp #(.STAGES(SYNC)) u_clamp (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .clamp_o(clamp));

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      assign wen_vec[i] = strobe_w && (addr_s == AW'(i));

      dacbank_chan #(.CW(CW), .FMT(FMT)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wen_vec[i]),
        .ld_n_i  (ld_s),
        .data_i  (data_s),
        .in_o    (in_flat[i*CW +: CW]),
        .dac_o   (dac_code[i*CW +: CW]));
    end
  endgenerate

  // R2: at most one channel written per cycle
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen_vec));
  // R2: a write strobe always reaches exactly one channel
  a_r2_decode: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_w |-> ($countones(wen_vec) == 1));
  // R5: after a load cycle every output equals its staging register
  a_r5_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> (dac_code == in_flat));
endmodule

// File: tb/sim_dacbank_top.sv
module sim_dacbank_top;
  import dacbank_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
  logic [2:0]   addr = '0;
  logic [13:0]  din = '0;
  logic [111:0] code0, code1;
  logic         clamp0, clamp1;

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_c [8];

  always #2.5 clk = ~clk;

  dacbank_top u0 (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n),
    .wr_n(wr_n), .ld_n(ld_n), .addr(addr), .din(din),
    .dac_code(code0), .clamp(clamp0));

  dacbank_top #(.FMT(FMT_TWOS)) u1 (.clk(clk), .rst_n(rst_n), .clr_n(clr_n),
    .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .addr(addr), .din(din),
    .dac_code(code1), .clamp(clamp1));

  function automatic logic [13:0] ch(input logic [111:0] v, input int k);
    return v[k*14 +: 14];
  endfunction

  function automatic logic [13:0] word(input int k);
    return 14'((k * 1931 + 300) % 16384);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_all(input string tag);
    for (int k = 0; k < 8; k++) chk(tag, 32'(ch(code0, k)), 32'(exp_c[k]));
  endtask

  task automatic write_ch(input int k, input logic [13:0] v);
    addr = 3'(k); din = v; cs_n = 1'b0; wr_n = 1'b0;
    wait_n(4);
    cs_n = 1'b1; wr_n = 1'b1;
    wait_n(4);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) exp_c[k] = '0;
    chk_all("R1 reset codes");
    chk("R1 reset clamp", 32'(clamp0), 32'd0);
  endtask

  task automatic t_decode_load;
    for (int k = 0; k < 8; k++) write_ch(k, word(k));
    chk_all("R4 hold while load high");
    ld_n = 1'b0;
    wait_n(2);
    chk_all("R7 no change before third edge");
    wait_n(1);
    for (int k = 0; k < 8; k++) exp_c[k] = word(k);
    chk_all("R2 R5 simultaneous transfer and decode");
    ld_n = 1'b1;
    wait_n(4);
    for (int k = 0; k < 8; k++)
      chk("R11 twos complement bit13", 32'(ch(code1, k)), 32'(word(k) ^ 14'h2000));
  endtask

  task automatic t_strobes;
    // R3: one strobe low only
    addr = 3'd2; din = 14'h1555; cs_n = 1'b0; wr_n = 1'b1; wait_n(4);
    cs_n = 1'b1; wr_n = 1'b0; wait_n(4);
    wr_n = 1'b1; wait_n(4);
    write_ch(3, 14'h0ABC);
    chk("R4 write under load high", 32'(ch(code0, 3)), 32'(exp_c[3]));
    ld_n = 1'b0; wait_n(4); ld_n = 1'b1; wait_n(4);
    exp_c[3] = 14'h0ABC;
    chk("R3 half strobe ignored", 32'(ch(code0, 2)), 32'(exp_c[2]));
    chk("R5 staged value transferred", 32'(ch(code0, 3)), 32'(exp_c[3]));
  endtask

  task automatic t_pass;
    logic [13:0] seq [3];
    seq[0] = 14'h3FFF; seq[1] = 14'h0000; seq[2] = 14'h2A5A;
    addr = 3'd5; din = 14'h1111;
    cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
    wait_n(4);
    exp_c[5] = 14'h1111;
    chk("R6 pass-through entry", 32'(ch(code0, 5)), 32'(exp_c[5]));
    for (int j = 0; j < 3; j++) begin
      din = seq[j];
      wait_n(2);
      chk("R7 pass-through latency", 32'(ch(code0, 5)), 32'(exp_c[5]));
      wait_n(1);
      exp_c[5] = seq[j];
      chk("R6 pass-through follows", 32'(ch(code0, 5)), 32'(exp_c[5]));
    end
    cs_n = 1'b1; wr_n = 1'b1; wait_n(4);
    ld_n = 1'b1; wait_n(4);
    chk_all("R2 other channels untouched");
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    chk("R8 clamp without clock", 32'(clamp0), 32'd1);
    wait_n(5);
    chk_all("R10 codes during clear");
    clr_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 clamp after first edge", 32'(clamp0), 32'd1);
    @(posedge clk); #1;
    chk("R9 clamp after second edge", 32'(clamp0), 32'd0);
    wait_n(2);
    chk_all("R10 codes after clear");
    ld_n = 1'b0; wait_n(4); ld_n = 1'b1; wait_n(4);
    chk_all("R10 staging kept across clear");
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0;
    wait_n(2);
    for (int k = 0; k < 8; k++) exp_c[k] = '0;
    chk_all("R1 reset clears codes");
    rst_n = 1'b1;
    wait_n(2);
  endtask

  initial begin
    wait_n(3);
    t_reset;
    rst_n = 1'b1;
    wait_n(3);
    t_decode_load;
    t_strobes;
    t_pass;
    t_clear;
    t_reset_again;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule